// File: doc/BRIEF.md
# Serial NAPOT Memory Protection Checker

This block guards memory for a small processor core. Machine-mode software programs a set of protection regions through a register write port. Each region has an 8-bit configuration register and an address register. The address register uses the naturally aligned power-of-two (NAPOT) encoding: the count of trailing ones in the register gives the size of the region. The core presents each load, store or instruction fetch on a check port, together with its privilege level. In the same cycle the block answers grant or fault. It compares the address against every decoded region in parallel.

The regions are not decoded one per region. A single decoder is shared by all of them. After every accepted register write it walks the regions in order, one per clock, and rebuilds a table of base and mask values. During the walk a busy output is high, and every check made in that time is refused. Matching regions have no priority order. An access gets every permission held by any region that covers it.

Top module: `napot_prot_chk`

## Requirements
- R1: A register write takes effect only when the writer's privilege is machine mode (`csr_priv` = 2'b11). A write at any other privilege changes no region and does not start a decode walk.
- R2: `csr_sel`=0 selects the configuration register, with fields R=bit0, W=bit1, X=bit2, mode=bits4:3 and lock=bit7. `csr_sel`=1 selects the address register, which takes byte address bits [AW-1:2] from `csr_wdata[AW-3:0]`. A region is enabled only when its mode is 2'b11 (NAPOT). Every other mode value leaves the region disabled.
- R3: An address register with k trailing ones describes a naturally aligned region of 2^(k+3) bytes. A check address matches when the address and the region base agree in every bit above the region size.
- R4: The parameter `GRAN_LOG2` (default 3, meaning 8 bytes) sets a minimum region size of 2^GRAN_LOG2 bytes. A smaller encoded region grows to that size.
- R5: An accepted write raises `busy` from the next cycle for exactly NREG cycles. A further accepted write during the walk restarts the count. While `busy` is high, every valid check faults, whatever its privilege.
- R6: A supervisor or user access (`chk_priv` other than 2'b11) is granted when any matching enabled region holds the needed permission. The permissions of all matching regions are merged.
- R7: A supervisor or user access that matches no enabled region faults.
- R8: A machine-mode access is granted unless a matching region is locked. In that case it needs the permission from the union of the matching locked regions.
- R9: A region whose lock bit is set ignores writes to both of its registers until reset.
- R10: `chk_grant` and `chk_fault` are combinational in the cycle of `chk_valid`. Both are 0 when `chk_valid` is 0. The access type is 2'b00 read, 2'b01 write, 2'b10 execute; 2'b11 always faults.
- R11: After reset all regions are disabled, unlocked and not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 configuration, 1 address register |
| csr_idx | input | $clog2(NREG) | Region index |
| csr_wdata | input | AW | Write data |
| csr_priv | input | 2 | Privilege of the writer |
| busy | output | 1 | Decode walk in progress |
| chk_valid | input | 1 | Access check request |
| chk_addr | input | AW | Byte address to check |
| chk_type | input | 2 | Access type |
| chk_priv | input | 2 | Privilege of the access |
| chk_grant | output | 1 | Access permitted |
| chk_fault | output | 1 | Access refused |

## Verification
The hardest situation to reach is a permission that comes only from merging regions. This needs several overlapping regions of different sizes, each with a different permission, laid over the same addresses. Directed writes build nested 64- and 128-byte regions with R, W and X split between them. A random phase then draws addresses close to the programmed bases, so the region edges are exercised often. Separate steps cover a write arriving in the middle of a walk, which must restart the busy count, and writes aimed at a locked region, which must be refused.

// File: rtl/napot_pkg.sv
package napot_pkg;
   localparam logic [1:0] PRIV_M     = 2'b11;
   localparam logic [1:0] MODE_NAPOT = 2'b11;
   localparam int CFG_R    = 0;
   localparam int CFG_W    = 1;
   localparam int CFG_X    = 2;
   localparam int CFG_MLO  = 3;
   localparam int CFG_LOCK = 7;
   localparam int CFG_W8   = 8;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_BAD   = 2'b11
   } acc_e;

   function automatic logic [2:0] need_perm(input logic [1:0] t);
      case (t)
         ACC_READ:  need_perm = 3'b001;
         ACC_WRITE: need_perm = 3'b010;
         ACC_EXEC:  need_perm = 3'b100;
         default:   need_perm = 3'b000;
      endcase
   endfunction
endpackage

// File: rtl/napot_csr_regs.sv
module napot_csr_regs
   import napot_pkg::*;
#(
   parameter int NREG = 16,
   parameter int AW   = 32,
   localparam int IW  = $clog2(NREG),
   localparam int RW  = AW - 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we_i,
   input  logic                           sel_i,
   input  logic [IW-1:0]                  idx_i,
   input  logic [AW-1:0]                  wdata_i,
   input  logic [1:0]                     priv_i,
   output logic [NREG-1:0][CFG_W8-1:0]    cfg_o,
   output logic [NREG-1:0][RW-1:0]        areg_o,
   output logic                           accept_o
);
   logic [NREG-1:0][CFG_W8-1:0] cfg_q;
   logic [NREG-1:0][RW-1:0]     areg_q;

   assign accept_o = we_i && (priv_i == PRIV_M) && !cfg_q[idx_i][CFG_LOCK];
   assign cfg_o    = cfg_q;
   assign areg_o   = areg_q;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[i]  <= '0;
            areg_q[i] <= '0;
         end else if (accept_o && (idx_i == IW'(i))) begin
            if (sel_i) areg_q[i] <= wdata_i[RW-1:0];
            else       cfg_q[i]  <= wdata_i[CFG_W8-1:0];
         end
      end

      // R9: a locked region holds both registers
      a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_q[i][CFG_LOCK] |=> (cfg_q[i] == $past(cfg_q[i]) && areg_q[i] == $past(areg_q[i])));
   end

   // R1: writes below machine mode leave every register untouched
   a_r1_priv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && priv_i != PRIV_M) |=> ($stable(cfg_q) && $stable(areg_q)));
endmodule

// File: rtl/napot_serial_dec.sv
module napot_serial_dec
   import napot_pkg::*;
#(
   parameter int NREG      = 16,
   parameter int AW        = 32,
   parameter int GRAN_LOG2 = 3,
   localparam int IW       = $clog2(NREG),
   localparam int RW       = AW - 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [NREG-1:0][CFG_W8-1:0] cfg_i,
   input  logic [NREG-1:0][RW-1:0]     areg_i,
   output logic                        busy_o,
   output logic [NREG-1:0]             en_o,
   output logic [NREG-1:0][AW-1:0]     base_o,
   output logic [NREG-1:0][AW-1:0]     mask_o
);
   localparam logic [IW-1:0] LAST = IW'(NREG - 1);

   logic [IW-1:0]           ptr_q;
   logic                    busy_q;
   logic [NREG-1:0]         en_q;
   logic [NREG-1:0][AW-1:0] base_q, mask_q;

   logic [CFG_W8-1:0] cur_cfg;
   logic [RW-1:0]     cur_areg;
   logic [AW-1:0]     ones_low, gran_low, cur_mask, cur_base;
   logic              cur_en;

   assign cur_cfg  = cfg_i[ptr_q];
   assign cur_areg = areg_i[ptr_q];

   // size from the run of trailing ones: prefix AND over the address register
   always_comb begin
      logic run;
      run      = 1'b1;
      ones_low = '0;
      ones_low[2:0] = 3'b111;
      for (int i = 3; i < AW; i++) begin
         run         = run & cur_areg[i-3];
         ones_low[i] = run;
      end
   end

   if (GRAN_LOG2 > 3) begin : g_coarse
      assign gran_low = {{(AW-GRAN_LOG2){1'b0}}, {GRAN_LOG2{1'b1}}};
   end else begin : g_fine
      assign gran_low = '0;
   end

   assign cur_mask = ~(ones_low | gran_low);
   assign cur_base = {cur_areg, 2'b00} & cur_mask;
   assign cur_en   = (cur_cfg[CFG_MLO+1:CFG_MLO] == MODE_NAPOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
         en_q   <= '0;
         base_q <= '0;
         mask_q <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         ptr_q  <= '0;
      end else if (busy_q) begin
         en_q[ptr_q]   <= cur_en;
         base_q[ptr_q] <= cur_base;
         mask_q[ptr_q] <= cur_mask;
         if (ptr_q == LAST) busy_q <= 1'b0;
         else               ptr_q  <= ptr_q + 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign en_o   = en_q;
   assign base_o = base_q;
   assign mask_o = mask_q;

   // R5: walk starts after an accepted write, at region 0, and ends after the last region
   a_r5_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (busy_q && ptr_q == '0));
   a_r5_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && ptr_q == LAST && !start_i) |=> !busy_q);
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start_i) |=> ($stable(en_q) && $stable(base_q) && $stable(mask_q)));
endmodule

// File: rtl/napot_match.sv
module napot_match
   import napot_pkg::*;
#(
   parameter int NREG = 16,
   parameter int AW   = 32
) (
   input  logic                        valid_i,
   input  logic [AW-1:0]               addr_i,
   input  logic [1:0]                  type_i,
   input  logic [1:0]                  priv_i,
   input  logic                        busy_i,
   input  logic [NREG-1:0]             en_i,
   input  logic [NREG-1:0][AW-1:0]     base_i,
   input  logic [NREG-1:0][AW-1:0]     mask_i,
   input  logic [NREG-1:0][CFG_W8-1:0] cfg_i,
   output logic                        grant_o,
   output logic                        fault_o
);
   logic [NREG-1:0] hit;
   logic [2:0]      any_perm, lock_perm, need;
   logic            lock_hit, allowed;

   for (genvar i = 0; i < NREG; i++) begin : g_cmp
      assign hit[i] = en_i[i] && ((addr_i & mask_i[i]) == base_i[i]);
   end

   always_comb begin
      any_perm  = '0;
      lock_perm = '0;
      lock_hit  = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) begin
            any_perm = any_perm | cfg_i[i][CFG_X:CFG_R];
            if (cfg_i[i][CFG_LOCK]) begin
               lock_perm = lock_perm | cfg_i[i][CFG_X:CFG_R];
               lock_hit  = 1'b1;
            end
         end
      end
   end

   assign need = need_perm(type_i);

   always_comb begin
      if (busy_i || need == 3'b000)  allowed = 1'b0;
      else if (priv_i == PRIV_M)     allowed = lock_hit ? |(lock_perm & need) : 1'b1;
      else                           allowed = |(any_perm & need);
   end

   assign grant_o = valid_i && allowed;
   assign fault_o = valid_i && !allowed;

   // R7: no enabled region covers a lower-privilege access, so it cannot be granted
   always_comb begin
      if (valid_i && priv_i != PRIV_M && hit == '0)
         a_r7_nomatch_deny: assert (!grant_o);
   end
endmodule

// File: rtl/napot_prot_chk.sv
module napot_prot_chk
   import napot_pkg::*;
#(
   parameter int NREG      = 16,
   parameter int AW        = 32,
   parameter int GRAN_LOG2 = 3,
   localparam int IW       = $clog2(NREG),
   localparam int RW       = AW - 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_we,
   input  logic          csr_sel,
   input  logic [IW-1:0] csr_idx,
   input  logic [AW-1:0] csr_wdata,
   input  logic [1:0]    csr_priv,
   output logic          busy,
   input  logic          chk_valid,
   input  logic [AW-1:0] chk_addr,
   input  logic [1:0]    chk_type,
   input  logic [1:0]    chk_priv,
   output logic          chk_grant,
   output logic          chk_fault
);
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8");
   end
   if (GRAN_LOG2 < 3 || GRAN_LOG2 >= AW) begin : g_bad_gran
      $error("GRAN_LOG2 must lie in 3 .. AW-1");
   end

   logic [NREG-1:0][CFG_W8-1:0] cfg;
   logic [NREG-1:0][RW-1:0]     areg;
   logic                        accept;
   logic [NREG-1:0]             en;
   logic [NREG-1:0][AW-1:0]     base, mask;

   napot_csr_regs #(.NREG(NREG), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(csr_we), .sel_i(csr_sel), .idx_i(csr_idx),
      .wdata_i(csr_wdata), .priv_i(csr_priv), .cfg_o(cfg), .areg_o(areg),
      .accept_o(accept)
   );

   napot_serial_dec #(.NREG(NREG), .AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_dec (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .cfg_i(cfg), .areg_i(areg),
      .busy_o(busy), .en_o(en), .base_o(base), .mask_o(mask)
   );

   napot_match #(.NREG(NREG), .AW(AW)) u_match (
      .valid_i(chk_valid), .addr_i(chk_addr), .type_i(chk_type), .priv_i(chk_priv),
      .busy_i(busy), .en_i(en), .base_i(base), .mask_i(mask), .cfg_i(cfg),
      .grant_o(chk_grant), .fault_o(chk_fault)
   );

   // R5: nothing is granted during a walk
   a_r5_busy_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && chk_valid) |-> chk_fault);
   // R10: exactly one answer per valid check, none otherwise
   a_r10_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |-> $onehot({chk_grant, chk_fault}));
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |-> (!chk_grant && !chk_fault));
   // R1: a write below machine mode never starts a walk
   a_r1_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && csr_we && csr_priv != PRIV_M) |=> !busy);
endmodule

// File: tb/napot_prot_chk_tb.sv
module napot_prot_chk_tb;
   localparam int N  = 16;
   localparam int AW = 32;
   localparam int RW = AW - 2;
   localparam int GC = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csr_we = 1'b0, csr_sel = 1'b0;
   logic [3:0] csr_idx = '0;
   logic [AW-1:0] csr_wdata = '0;
   logic [1:0] csr_priv = 2'b11;
   logic chk_valid = 1'b0;
   logic [AW-1:0] chk_addr = '0;
   logic [1:0] chk_type = '0, chk_priv = '0;
   logic busy, grant, fault, busy_g, grant_g, fault_g;

   int n_tests = 0, n_fail = 0;
   logic [7:0]    m_cfg [N];
   logic [RW-1:0] m_areg[N];

   always #4 clk = ~clk;

   napot_prot_chk #(.NREG(N), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_idx(csr_idx),
      .csr_wdata(csr_wdata), .csr_priv(csr_priv), .busy(busy), .chk_valid(chk_valid),
      .chk_addr(chk_addr), .chk_type(chk_type), .chk_priv(chk_priv),
      .chk_grant(grant), .chk_fault(fault));

   napot_prot_chk #(.NREG(N), .AW(AW), .GRAN_LOG2(GC)) u_dut_g (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_idx(csr_idx),
      .csr_wdata(csr_wdata), .csr_priv(csr_priv), .busy(busy_g), .chk_valid(chk_valid),
      .chk_addr(chk_addr), .chk_type(chk_type), .chk_priv(chk_priv),
      .chk_grant(grant_g), .chk_fault(fault_g));

   task automatic finish_tb();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_tb();
   end

   task automatic chk1(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference from the requirements: size by trailing-one count, compare above it
   function automatic bit region_hit(int r, logic [AW-1:0] a, int gran);
      int k, lb;
      logic [AW-1:0] b;
      if (m_cfg[r][4:3] != 2'b11) return 0;
      k = 0;
      while (k < RW && m_areg[r][k]) k++;
      lb = (k + 3 > gran) ? k + 3 : gran;
      if (lb >= AW) return 1;
      b = {m_areg[r], 2'b00};
      return (a >> lb) == (b >> lb);
   endfunction

   function automatic bit ref_allow(logic [AW-1:0] a, logic [1:0] t, logic [1:0] p, int gran);
      logic [2:0] anyp, lockp, need;
      bit lh;
      anyp = 0; lockp = 0; lh = 0;
      case (t) 2'b00: need = 3'b001; 2'b01: need = 3'b010; 2'b10: need = 3'b100; default: need = 0; endcase
      if (need == 0) return 0;
      for (int r = 0; r < N; r++) if (region_hit(r, a, gran)) begin
         anyp |= m_cfg[r][2:0];
         if (m_cfg[r][7]) begin lockp |= m_cfg[r][2:0]; lh = 1; end
      end
      if (p == 2'b11) return lh ? |(lockp & need) : 1'b1;
      return |(anyp & need);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      for (int r = 0; r < N; r++) begin m_cfg[r] = '0; m_areg[r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // returns at the falling edge after the write's capturing edge
   task automatic csr_wr(input bit sel, input int idx, input logic [AW-1:0] d, input logic [1:0] p);
      @(negedge clk);
      csr_we = 1'b1; csr_sel = sel; csr_idx = 4'(idx); csr_wdata = d; csr_priv = p;
      @(negedge clk);
      csr_we = 1'b0;
      if (p == 2'b11 && !m_cfg[idx][7]) begin
         if (sel) m_areg[idx] = d[RW-1:0];
         else     m_cfg[idx]  = d[7:0];
      end
      #1;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      #1;
   endtask

   task automatic drive_chk(input logic [AW-1:0] a, input logic [1:0] t, input logic [1:0] p);
      @(negedge clk);
      chk_valid = 1'b1; chk_addr = a; chk_type = t; chk_priv = p;
      #1;
   endtask

   task automatic acc(input string req, input logic [AW-1:0] a, input logic [1:0] t,
                      input logic [1:0] p, input bit exp);
      drive_chk(a, t, p);
      chk1(req, {grant, fault}, {exp, !exp});
      chk_valid = 1'b0;
   endtask

   initial begin
      int cnt;
      void'($urandom(32'h5eed_0042));
      do_reset();

      // R11 reset state
      chk1("R11 busy", busy, 0);
      acc("R11 S read denied", 32'h8000_0000, 2'b00, 2'b01, 0);
      acc("R11 M write granted", 32'h8000_0000, 2'b01, 2'b11, 1);
      #1 chk1("R10 idle outputs", {grant, fault}, 2'b00);

      // directed regions: 0 R 64B, 1 W 64B, 2 X 128B at 0x8000_0000; 3 mode 01
      csr_wr(1, 0, 32'h2000_0007, 2'b11); csr_wr(0, 0, 32'h19, 2'b11);
      csr_wr(1, 1, 32'h2000_0007, 2'b11); csr_wr(0, 1, 32'h1A, 2'b11);
      csr_wr(1, 2, 32'h2000_000F, 2'b11); csr_wr(0, 2, 32'h1C, 2'b11);
      csr_wr(1, 3, 32'h2400_0000, 2'b11); csr_wr(0, 3, 32'h0F, 2'b11);
      wait_idle();
      acc("R3 low edge", 32'h8000_0000, 2'b00, 2'b00, 1);
      acc("R3 high edge", 32'h8000_003F, 2'b00, 2'b00, 1);
      acc("R3 just past", 32'h8000_0040, 2'b00, 2'b00, 0);
      acc("R3 just below", 32'h7FFF_FFFF, 2'b00, 2'b01, 0);
      acc("R6 union W", 32'h8000_0010, 2'b01, 2'b01, 1);
      acc("R6 union X", 32'h8000_0010, 2'b10, 2'b00, 1);
      acc("R6 outer W denied", 32'h8000_0050, 2'b01, 2'b01, 0);
      acc("R6 outer X", 32'h8000_0050, 2'b10, 2'b01, 1);
      acc("R7 outside all", 32'h8000_0080, 2'b10, 2'b01, 0);
      acc("R2 non-NAPOT mode", 32'h9000_0000, 2'b00, 2'b01, 0);
      acc("R10 reserved type", 32'h8000_0000, 2'b11, 2'b01, 0);
      acc("R8 M unlocked", 32'h9000_0000, 2'b01, 2'b11, 1);

      // R5 busy length, denial during walk, restart
      csr_wr(0, 5, 32'h0, 2'b11);
      cnt = 0;
      while (busy) begin cnt++; @(negedge clk); #1; end
      chk1("R5 busy length", cnt, N);
      csr_wr(0, 5, 32'h0, 2'b11);
      acc("R5 S denied while busy", 32'h8000_0000, 2'b00, 2'b01, 0);
      acc("R5 M denied while busy", 32'h8000_0000, 2'b00, 2'b11, 0);
      repeat (5) @(negedge clk);
      csr_wr(0, 6, 32'h0, 2'b11);
      cnt = 0;
      while (busy) begin cnt++; @(negedge clk); #1; end
      chk1("R5 restart length", cnt, N);
      acc("R5 granted after walk", 32'h8000_0000, 2'b00, 2'b01, 1);

      // R1 write from supervisor ignored
      csr_wr(0, 0, 32'h0, 2'b01);
      chk1("R1 no walk", busy, 0);
      acc("R1 region kept", 32'h8000_0000, 2'b00, 2'b01, 1);

      // R4 coarse granularity: 8-byte region at 0x1000
      csr_wr(1, 4, 32'h0000_0400, 2'b11); csr_wr(0, 4, 32'h19, 2'b11);
      wait_idle();
      acc("R3 8B region", 32'h0000_1000, 2'b00, 2'b01, 1);
      acc("R3 8B past", 32'h0000_1008, 2'b00, 2'b01, 0);
      drive_chk(32'h0000_1008, 2'b00, 2'b01);
      chk1("R4 coarse inside", grant_g, 1);
      drive_chk(32'h0000_103F, 2'b00, 2'b01);
      chk1("R4 coarse top", grant_g, 1);
      drive_chk(32'h0000_1040, 2'b00, 2'b01);
      chk1("R4 coarse past", fault_g, 1);
      chk_valid = 1'b0;

      // random phase (no locks)
      for (int it = 0; it < 400; it++) begin
         if ($urandom_range(0, 9) < 3) begin
            int r, k;
            logic [RW-1:0] a;
            logic [1:0] p;
            r = $urandom_range(0, N - 1);
            k = $urandom_range(0, 12);
            a = RW'({($urandom_range(1, 2)) << 28} >> 2) | RW'($urandom_range(0, 32'hFFF));
            a = (a & ~((RW'(1) << (k + 1)) - 1)) | ((RW'(1) << k) - 1);
            p = ($urandom_range(0, 4) == 0) ? 2'b01 : 2'b11;
            if ($urandom_range(0, 1)) csr_wr(1, r, AW'(a), p);
            else csr_wr(0, r, AW'({1'b0, 2'b00, ($urandom_range(0, 3) == 0) ? 2'b01 : 2'b11,
                                   3'($urandom_range(0, 7))}), p);
            wait_idle();
         end else begin
            logic [AW-1:0] ad;
            logic [1:0] t, p;
            ad = ($urandom_range(0, 3) == 0) ? AW'($urandom)
               : (AW'($urandom_range(1, 2)) << 28) | AW'($urandom_range(0, 32'h3FFF));
            t = 2'($urandom_range(0, 3));
            p = 2'($urandom_range(0, 3));
            drive_chk(ad, t, p);
            chk1("R6 random", {grant, fault}, {ref_allow(ad, t, p, 3), !ref_allow(ad, t, p, 3)});
            chk1("R4 random coarse", grant_g, ref_allow(ad, t, p, GC));
            chk_valid = 1'b0;
         end
      end

      // R8/R9 locking
      do_reset();
      csr_wr(1, 0, 32'h2000_0007, 2'b11); csr_wr(0, 0, 32'h99, 2'b11);
      csr_wr(1, 1, 32'h2000_0007, 2'b11); csr_wr(0, 1, 32'h1A, 2'b11);
      wait_idle();
      acc("R8 M write locked", 32'h8000_0000, 2'b01, 2'b11, 0);
      acc("R8 M read locked", 32'h8000_0000, 2'b00, 2'b11, 1);
      acc("R8 M elsewhere", 32'h9000_0000, 2'b01, 2'b11, 1);
      acc("R6 S write via unlocked", 32'h8000_0000, 2'b01, 2'b00, 1);
      csr_wr(0, 0, 32'h1F, 2'b11);
      chk1("R9 no walk on locked cfg", busy, 0);
      acc("R9 cfg kept", 32'h8000_0000, 2'b01, 2'b11, 0);
      csr_wr(1, 0, 32'h2400_0007, 2'b11);
      chk1("R9 no walk on locked addr", busy, 0);
      acc("R9 addr kept", 32'h8000_0000, 2'b01, 2'b11, 0);
      acc("R9 not moved", 32'h9000_0000, 2'b01, 2'b11, 1);

      do_reset();
      chk1("R11 busy after reset", busy, 0);
      acc("R11 lock cleared", 32'h8000_0000, 2'b01, 2'b11, 1);
      acc("R11 S denied", 32'h8000_0000, 2'b00, 2'b01, 0);
      finish_tb();
   end
endmodule